// File: doc/BRIEF.md
# Grouped-Priority Nested Interrupt Arbiter

This block arbitrates among a set of interrupt sources and decides when one of them may interrupt the handler that is running. Each source has a registered pending flag. That flag is set from several trigger inputs, and each trigger input has its own enable. A source-level enable gates both the setting of the flag and the taking of the request. Software uses a small register port to program an 8-bit priority byte per source, a 3-bit grouping code, the enables and the pending flags.

The grouping code splits the four implemented priority bits at run time into two fields:

- The upper field is the preemption level. Only this field can nest one handler inside another.
- The lower field is the sub-priority. It only orders requests that are waiting together.

The block offers the winning source to the CPU through a request/acknowledge pair. An acknowledge pushes the winner's preemption level onto an active-level stack. A handler-done strobe pops that stack.

Top module: `irq_group_arb`

## Requirements
- R1: The priority byte of source i is at register address i. Only bits [7:4] are stored. Reads return the stored nibble in bits [7:4] and zero in bits [3:0].
- R2: The grouping code is at address 8, bits [2:0]. Codes 7, 6, 5 and 4 give 0, 1, 2 and 3 preemption bits, taken from the top of the nibble. Codes 3 to 0 all give 4 preemption bits.
- R3: A source is eligible when it is pending and its source enable is set. Among eligible sources, the winner has the numerically lowest 4-bit priority nibble. That is, the lowest preemption field wins first, then the lowest sub-priority. A tie goes to the lower source index.
- R4: When a handler is active, the winner is offered only if its preemption field is strictly lower than the preemption field of the innermost active handler. An equal field waits, whatever the sub-priority.
- R5: When no handler is active (stack empty), any eligible winner is offered.
- R6: The pending flag of source s is set when trigger input s*NUM_SIG+k is high while two enables are also set:
  - bit s*NUM_SIG+k of the signal-enable register (address 10);
  - bit s of the source-enable register (address 9).
  A set in the same cycle as a clear leaves the flag set.
- R7: Pending flags read at address 11. Writing a 1 to bit s there clears flag s. A flag that is never cleared stays set, so its source is offered again after its handler returns.
- R8: `takeReq` and `takeIdx` are registered. They respond one clock after a pending flag, a priority byte or the grouping code changes. `takeReq` drops in the cycle after it is acknowledged.
- R9: Each acknowledge raises `nestDepth` by one and each `handlerDone` lowers it by one. A `handlerDone` with an empty stack leaves the depth at 0. The stack holds up to 16 levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sigIn | input | NUM_SRC*NUM_SIG | Trigger inputs, NUM_SIG per source |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| takeReq | output | 1 | A source is offered to the CPU |
| takeIdx | output | log2(NUM_SRC) | Index of the offered source |
| takeAck | input | 1 | CPU accepts the offered source |
| handlerDone | input | 1 | Innermost handler has returned |
| nestDepth | output | 5 | Number of active nested handlers |

## Verification
The results fall due at different points after a stimulus:

- A trigger pulse sets its pending flag at the next clock edge.
- An offer appears one edge after that.
- A register write becomes readable right after its edge.
- A change of priority or grouping shows on `takeReq` one edge later.
- An acknowledge or a done strobe moves `nestDepth` at the edge on which it is sampled.

The bench drives all inputs on falling edges. It samples outputs at the falling edge that follows the last register on each path, and it checks one falling edge early where the absence of a premature response matters. The preemption and selection sweeps compute the expected preemption field arithmetically, as a right shift, for every grouping code and every pair of priority nibbles.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // implemented priority bits per source
  localparam int PRIO_W = 4;
  // stack entry: one guard bit above the field, so "empty" is less urgent than any level
  localparam int LVL_W  = PRIO_W + 1;

  typedef struct packed {
    logic             push;
    logic             pop;
    logic [LVL_W-1:0] lvl;
  } arbStrobe_t;
endpackage

// File: rtl/irq_arb_dp.sv
module irq_arb_dp
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int NUM_SIG = 2,
  parameter int ADDR_W  = 4,
  localparam int IW     = $clog2(NUM_SRC),
  localparam int SIGW   = NUM_SRC * NUM_SIG,
  localparam int DEPTH  = 1 << PRIO_W,
  localparam int SPW    = $clog2(DEPTH),
  localparam int DW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SIGW-1:0]   sigIn,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  arbStrobe_t        st,
  output logic              cand,
  output logic [IW-1:0]     candIdx,
  output logic [LVL_W-1:0]  candLvl,
  output logic [DW-1:0]     depth
);
  localparam logic [ADDR_W-1:0] A_GRP  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_SEN  = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_GEN  = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(11);

  logic [PRIO_W-1:0] prio [NUM_SRC];
  logic [2:0]        group;
  logic [NUM_SRC-1:0] srcEn, pend, setHit, clrHit;
  logic [SIGW-1:0]   sigEn;
  logic [LVL_W-1:0]  stackMem [DEPTH];
  logic [DW-1:0]     depthQ;
  logic [LVL_W-1:0]  stackTop;

  // keep only the preemption bits selected by the grouping code
  function automatic logic [PRIO_W-1:0] preField(input logic [PRIO_W-1:0] p,
                                                 input logic [2:0] g);
    int pb;
    pb = 7 - int'(g);
    if (pb > PRIO_W) pb = PRIO_W;
    preField = '0;
    for (int b = 0; b < PRIO_W; b++)
      if (b >= PRIO_W - pb) preField[b] = p[b];
  endfunction

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign setHit[s] = srcEn[s] & (|(sigIn[s*NUM_SIG +: NUM_SIG] & sigEn[s*NUM_SIG +: NUM_SIG]));
    assign clrHit[s] = regWe && regAddr == A_PEND && regWdata[s];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prio[s] <= '0;
        pend[s] <= 1'b0;
      end else begin
        if (regWe && regAddr == ADDR_W'(s)) prio[s] <= regWdata[7 -: PRIO_W];
        pend[s] <= setHit[s] | (pend[s] & ~clrHit[s]);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      group <= '0;
      srcEn <= '0;
      sigEn <= '0;
    end else if (regWe) begin
      if (regAddr == A_GRP) group <= regWdata[2:0];
      if (regAddr == A_SEN) srcEn <= regWdata[NUM_SRC-1:0];
      if (regAddr == A_GEN) sigEn <= regWdata[SIGW-1:0];
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr < ADDR_W'(NUM_SRC)) regRdata[7 -: PRIO_W] = prio[IW'(regAddr)];
    else if (regAddr == A_GRP)  regRdata[2:0] = group;
    else if (regAddr == A_SEN)  regRdata[NUM_SRC-1:0] = srcEn;
    else if (regAddr == A_GEN)  regRdata[SIGW-1:0] = sigEn;
    else if (regAddr == A_PEND) regRdata[NUM_SRC-1:0] = pend;
  end

  // winner: lowest full nibble; strict compare keeps the lower index on ties
  logic              found;
  logic [PRIO_W-1:0] bestPri;
  always_comb begin
    found   = 1'b0;
    bestPri = '1;
    candIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i] && srcEn[i] && (!found || prio[i] < bestPri)) begin
        found   = 1'b1;
        bestPri = prio[i];
        candIdx = IW'(i);
      end
    end
  end

  assign stackTop = (depthQ == '0) ? LVL_W'(DEPTH) : stackMem[SPW'(depthQ - 1'b1)];
  assign candLvl  = {1'b0, preField(bestPri, group)};
  assign cand     = found && (candLvl < stackTop);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depthQ <= '0;
      for (int i = 0; i < DEPTH; i++) stackMem[i] <= '0;
    end else begin
      unique case ({st.push, st.pop && depthQ != '0})
        2'b10: begin
          stackMem[SPW'(depthQ)] <= st.lvl;
          depthQ <= depthQ + 1'b1;
        end
        2'b01: depthQ <= depthQ - 1'b1;
        2'b11: stackMem[SPW'(depthQ - 1'b1)] <= st.lvl;
        default: ;
      endcase
    end
  end
  assign depth = depthQ;

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.push |-> depthQ < DW'(DEPTH));
  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.pop && !st.push && depthQ == '0) |=> depthQ == '0);
  // R9
  push_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.push && !st.pop) |=> depthQ == $past(depthQ) + 1'b1);
  // R4
  push_urgency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.push && !st.pop && depthQ != '0) |-> st.lvl < stackTop);
  // R1
  prio_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr < ADDR_W'(NUM_SRC)) |-> regRdata[7-PRIO_W:0] == '0);
endmodule

// File: rtl/irq_arb_ctrl.sv
module irq_arb_ctrl
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 4,
  localparam int IW     = $clog2(NUM_SRC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cand,
  input  logic [IW-1:0]    candIdx,
  input  logic [LVL_W-1:0] candLvl,
  input  logic             takeAck,
  input  logic             handlerDone,
  output logic             takeReq,
  output logic [IW-1:0]    takeIdx,
  output arbStrobe_t       st
);
  logic [LVL_W-1:0] lvlQ;
  logic             accept;

  assign accept = takeReq & takeAck;

  // the decision is registered; an accepted offer is withdrawn for one cycle
  // so the next decision sees the updated stack
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      takeReq <= 1'b0;
      takeIdx <= '0;
      lvlQ    <= '0;
    end else begin
      takeReq <= cand & ~accept;
      takeIdx <= candIdx;
      lvlQ    <= candLvl;
    end
  end

  assign st.push = accept;
  assign st.pop  = handlerDone;
  assign st.lvl  = lvlQ;

  // R8
  single_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !takeReq);
  // R8
  offer_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeReq && !takeAck && $past(cand) && cand && $stable(candIdx)) |=> takeReq);
endmodule

// File: rtl/irq_group_arb.sv
module irq_group_arb
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int NUM_SIG = 2,
  parameter int ADDR_W  = 4,
  localparam int IW     = $clog2(NUM_SRC),
  localparam int DW     = $clog2((1 << PRIO_W) + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SRC*NUM_SIG-1:0] sigIn,
  input  logic                       regWe,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [7:0]                 regWdata,
  output logic [7:0]                 regRdata,
  output logic                       takeReq,
  output logic [IW-1:0]              takeIdx,
  input  logic                       takeAck,
  input  logic                       handlerDone,
  output logic [DW-1:0]              nestDepth
);
  arbStrobe_t       st;
  logic             cand;
  logic [IW-1:0]    candIdx;
  logic [LVL_W-1:0] candLvl;

  irq_arb_dp #(.NUM_SRC(NUM_SRC), .NUM_SIG(NUM_SIG), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .st(st), .cand(cand),
    .candIdx(candIdx), .candLvl(candLvl), .depth(nestDepth)
  );

  irq_arb_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk(clk), .rstN(rstN), .cand(cand), .candIdx(candIdx), .candLvl(candLvl),
    .takeAck(takeAck), .handlerDone(handlerDone), .takeReq(takeReq),
    .takeIdx(takeIdx), .st(st)
  );
endmodule

// File: tb/sim_irq_group_arb.sv
`timescale 1ns/1ps
module sim_irq_group_arb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] sigIn = '0;
  logic       regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       takeReq;
  logic [1:0] takeIdx;
  logic       takeAck = 1'b0;
  logic       handlerDone = 1'b0;
  logic [4:0] nestDepth;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  irq_group_arb u0 (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .takeReq(takeReq), .takeIdx(takeIdx),
    .takeAck(takeAck), .handlerDone(handlerDone), .nestDepth(nestDepth)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    regWe = 1'b1; regAddr = 4'(a); regWdata = 8'(d);
    tick();
    regWe = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    regAddr = 4'(a);
    #1;
    d = int'(regRdata);
  endtask

  task automatic pulse(input int v);
    sigIn = 8'(v);
    tick();
    sigIn = '0;
  endtask

  task automatic ack();
    takeAck = 1'b1; tick(); takeAck = 1'b0;
  endtask

  task automatic done();
    handlerDone = 1'b1; tick(); handlerDone = 1'b0;
  endtask

  function automatic int preOf(input int p, input int g);
    int pb;
    pb = (g >= 4) ? 7 - g : 4;
    return p >> (4 - pb);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d;
    tick(); tick();
    rstN = 1'b1;
    tick();

    // reset state
    chk(takeReq == 1'b0, "R8 reset takeReq", int'(takeReq), 0);
    chk(nestDepth == 0, "R9 reset depth", int'(nestDepth), 0);
    rd(11, d); chk(d == 0, "R7 reset pending", d, 0);
    rd(8, d);  chk(d == 0, "R2 reset group", d, 0);

    // R1: upper nibble kept, lower nibble reads zero
    for (int i = 0; i < 4; i++) begin
      wr(i, ((i + 9) << 4) | 4'hB);
      rd(i, d);
      chk(d == ((i + 9) << 4), "R1 prio readback", d, (i + 9) << 4);
    end
    wr(8, 8'hFD); rd(8, d); chk(d == 5, "R2 group readback", d, 5);

    // R6: both enables needed
    wr(9, 8'h00); wr(10, 8'h10);
    pulse(8'h10); rd(11, d); chk(d == 0, "R6 source enable off", d, 0);
    wr(9, 8'h04); wr(10, 8'h20);
    pulse(8'h10); rd(11, d); chk(d == 0, "R6 signal enable off", d, 0);
    pulse(8'h20); rd(11, d); chk(d == 4, "R6 both enables", d, 4);
    wr(11, 8'h04); rd(11, d); chk(d == 0, "R7 clear", d, 0);
    sigIn = 8'h20; wr(11, 8'h04); sigIn = '0;
    rd(11, d); chk(d == 4, "R6 set beats clear", d, 4);
    wr(11, 8'h04); tick(); tick();

    wr(9, 8'h0F); wr(10, 8'hFF);

    // R3/R5: simultaneous selection in thread mode, all groups
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        wr(8, (a + b) % 8);
        wr(0, a << 4); wr(1, b << 4);
        pulse(8'h05); tick();
        chk(takeReq == 1'b1, "R5 thread offer", int'(takeReq), 1);
        chk(int'(takeIdx) == ((b < a) ? 1 : 0), "R3 winner", int'(takeIdx), (b < a) ? 1 : 0);
        wr(11, 8'h03); tick(); tick();
      end
    end

    // R4/R2: preemption decision for every grouping code
    for (int g = 0; g < 8; g++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          bit expP;
          wr(8, g); wr(0, a << 4); wr(1, b << 4);
          pulse(8'h01); tick();
          ack();
          wr(11, 8'h01);
          pulse(8'h04); tick();
          expP = preOf(b, g) < preOf(a, g);
          chk(takeReq == expP, "R4 preempt decision", int'(takeReq), int'(expP));
          if (expP) chk(takeIdx == 2'd1, "R4 preempt index", int'(takeIdx), 1);
          wr(11, 8'h02); done(); tick(); tick();
        end
      end
    end
    chk(nestDepth == 0, "R9 sweep depth", int'(nestDepth), 0);

    // R7: uncleared pending is offered again after return
    wr(8, 3); wr(2, 8'h70);
    pulse(8'h10); tick();
    chk(takeReq && takeIdx == 2'd2, "R7 first offer", int'(takeIdx), 2);
    ack();
    chk(takeReq == 1'b0, "R8 drop after ack", int'(takeReq), 0);
    chk(nestDepth == 1, "R9 push", int'(nestDepth), 1);
    done();
    chk(nestDepth == 0, "R9 pop", int'(nestDepth), 0);
    tick();
    chk(takeReq && takeIdx == 2'd2, "R7 retaken", int'(takeReq), 1);
    wr(11, 8'h04); tick(); tick();

    // R3: source enable also gates taking; flag remains
    wr(3, 8'h10); pulse(8'h40); wr(9, 8'h07); tick();
    chk(takeReq == 1'b0, "R3 disabled not offered", int'(takeReq), 0);
    rd(11, d); chk(d == 8, "R7 flag kept", d, 8);
    wr(9, 8'h0F); tick();
    chk(takeReq && takeIdx == 2'd3, "R3 re-enabled offer", int'(takeIdx), 3);
    wr(11, 8'h08); tick(); tick();

    // R9: nest four levels with 4 preemption bits
    wr(8, 3);
    wr(3, 8'hC0); wr(2, 8'h80); wr(1, 8'h40); wr(0, 8'h00);
    for (int k = 0; k < 4; k++) begin
      int s;
      s = 3 - k;
      pulse(1 << (2 * s)); tick();
      chk(takeReq && int'(takeIdx) == s, "R4 nested offer", int'(takeIdx), s);
      ack();
      wr(11, 1 << s);
      chk(nestDepth == 5'(k + 1), "R9 nest depth", int'(nestDepth), k + 1);
    end
    for (int k = 4; k > 0; k--) begin
      done();
      chk(nestDepth == 5'(k - 1), "R9 unwind depth", int'(nestDepth), k - 1);
    end
    done();
    chk(nestDepth == 0, "R9 pop at empty", int'(nestDepth), 0);

    // R8: raising urgency by a priority write takes effect one clock later
    wr(8, 3); wr(0, 8'h50); wr(1, 8'h90);
    pulse(8'h01); tick(); ack(); wr(11, 8'h01);
    pulse(8'h04); tick();
    chk(takeReq == 1'b0, "R4 less urgent waits", int'(takeReq), 0);
    wr(1, 8'h20);
    chk(takeReq == 1'b0, "R8 not same cycle", int'(takeReq), 0);
    tick();
    chk(takeReq && takeIdx == 2'd1, "R8 offer after write", int'(takeReq), 1);
    wr(11, 8'h02); done(); tick(); tick();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule